// File: doc/BRIEF.md
# PCM Serial Frame Formatter

This block is the transmit half of a serial audio port that generates its own bit clock and frame sync. It divides the system clock down to a bit period and steps a position counter through a programmable frame. It places up to two channel samples, MSB first, at positions given by a channel configuration word. Samples come from a ready/valid word source: either one 32-bit word per channel, or, in packed mode, one word whose halves feed both channels.

Clock and sync polarity are selectable, so standard I2S, left-justified and DSP-style framing can all be set up without changing the datapath. Two bit-clock-timed helpers sit alongside the serializer. A sync bit is echoed back after two bit periods, so firmware can tell when the serial clock domain has moved on. A clear request is turned into a one-cycle strobe for the upstream FIFO after two bit periods.

A bit period is `CLK_DIV` system clocks (`CLK_DIV` even, at least 2). A bit period starts where the normalised bit clock falls; all timing below counts those falls as "bit clocks".

Top module: `pcm_tx_framer`

## Requirements
- R1: A frame lasts `frame_len` + 1 bit clocks; the sync window covers the first `sync_len` bits of every frame (`sync_len` must be below the frame length).
- R2: `chan_cfg[31:16]` configures channel 1 and `chan_cfg[15:0]` channel 2. In each half, bits 3:0 are a width code, bits 13:4 the start position, bit 14 the enable and bit 15 a width extension. Width = code + 8, plus 16 when the extension is set (8 to 39 bits).
- R3: In unpacked mode each enabled channel takes one word at its start position. The word is sent MSB first from that position for the channel width. Bits beyond the 32nd and all positions outside an enabled channel send 0.
- R4: In packed mode one word is taken per frame: at channel 1's start if it is enabled, otherwise at channel 2's. Channel 1 sends the upper 16 bits and channel 2 the lower 16 bits, each left-aligned, with 0 after the 16th bit.
- R5: With `bclk_inv` = 1 the bit clock is low in the first half of each bit, so data changes on its falling edge and is stable on its rising edge; with 0 it is inverted. With `fs_inv` = 1 `fsync` is low inside the sync window; with 0 it is high.
- R6: If no word is valid when one is due, the channel sends zeros and `tx_err` is set. `tx_err` stays set until `en` is lowered.
- R7: With `tx_on` low or `stby_n` low, no word is accepted (`s_ready` stays low) and the sync window never opens.
- R8: After `stby_n` rises with `en` and `tx_on` high, the first frame begins on the fifth bit clock.
- R9: `sync_echo` shows the value of `sync_wr` two bit clocks after it changes, and still shows the old value after one.
- R10: A `clr_req` pulse yields a single-cycle `fifo_clr` on the second bit clock after it.
- R11: After reset with `en` low: `sdata`, `s_ready`, `tx_err`, `sync_echo` and `fifo_clr` are 0; the bit clock and `fsync` rest at their inactive levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Global enable; runs the bit-clock divider |
| stby_n | input | 1 | Leave standby (1 = awake) |
| tx_on | input | 1 | Transmit on |
| frame_len | input | 10 | Frame length minus one, in bits |
| sync_len | input | 10 | Sync window length in bits |
| pack | input | 1 | Packed two-channel word mode |
| bclk_inv | input | 1 | Bit clock polarity select |
| fs_inv | input | 1 | Frame sync polarity select |
| chan_cfg | input | 32 | Channel 1 (upper) and channel 2 (lower) configuration |
| s_data | input | 32 | Sample word |
| s_valid | input | 1 | Sample word valid |
| s_ready | output | 1 | Sample word taken this cycle |
| sync_wr | input | 1 | Sync bit written by software |
| sync_echo | output | 1 | Sync bit after two bit clocks |
| clr_req | input | 1 | FIFO clear request pulse |
| fifo_clr | output | 1 | FIFO clear strobe |
| bclk | output | 1 | Bit clock |
| fsync | output | 1 | Frame sync |
| sdata | output | 1 | Serial data |
| tx_err | output | 1 | Sticky underflow flag |

## Verification
The bench builds the block with `CLK_DIV` = 2, the shortest bit period. A bit boundary then falls on every other system clock, so the delay counters for standby, sync echo and clear are tested at their tightest spacing, against a free-running sample source. The 10-bit frame fields let random frames reach 39-bit channels. There the zero padding past the 32nd bit, gaps between channels and odd sync lengths all come into play, together with every polarity combination and both packing modes.

// File: rtl/pcm_tx_framer.sv
module pcm_tx_framer #(
  parameter int CLK_DIV = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        en,
  input  logic        stby_n,
  input  logic        tx_on,
  input  logic [9:0]  frame_len,
  input  logic [9:0]  sync_len,
  input  logic        pack,
  input  logic        bclk_inv,
  input  logic        fs_inv,
  input  logic [31:0] chan_cfg,
  input  logic [31:0] s_data,
  input  logic        s_valid,
  output logic        s_ready,
  input  logic        sync_wr,
  output logic        sync_echo,
  input  logic        clr_req,
  output logic        fifo_clr,
  output logic        bclk,
  output logic        fsync,
  output logic        sdata,
  output logic        tx_err
);
  localparam int CW   = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
  localparam int HALF = CLK_DIV / 2;

  logic [CW-1:0] div_cnt;
  logic [2:0]    wake_cnt;
  logic          tick, run, active, fs_r, sd_r, sync_s1, clr_pend, clr_cnt;
  logic [9:0]    pos, nxt_pos;
  logic [31:0]   smp [2];

  assign tick = en && (div_cnt == CW'(CLK_DIV - 1));
  assign run  = tx_on && (wake_cnt == 3'd4);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)               div_cnt <= '0;
    else if (!en || tick)     div_cnt <= '0;
    else                      div_cnt <= div_cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                          wake_cnt <= '0;
    else if (!en || !stby_n)             wake_cnt <= '0;
    else if (tick && wake_cnt != 3'd4)   wake_cnt <= wake_cnt + 3'd1;

  assign nxt_pos = !active ? 10'd0 : (pos == frame_len) ? 10'd0 : pos + 10'd1;

  logic [15:0] ccfg [2];
  logic [1:0]  c_en, c_hit, c_in, c_ld, c_bit;
  logic [9:0]  c_off [2];
  logic [5:0]  c_w [2];
  logic [31:0] c_new [2], c_cur [2];
  logic [31:0] word;
  logic        fetch, nxt_bit;

  assign ccfg[0] = chan_cfg[31:16];
  assign ccfg[1] = chan_cfg[15:0];

  assign fetch   = pack ? (c_en[0] ? c_hit[0] : c_hit[1]) : |c_hit;
  assign s_ready = tick && run && fetch;
  assign word    = s_valid ? s_data : 32'd0;
  assign c_new[0] = pack ? {word[31:16], 16'h0} : word;
  assign c_new[1] = pack ? {word[15:0], 16'h0}  : word;

  always_comb
    for (int c = 0; c < 2; c++) begin
      c_en[c]  = ccfg[c][14];
      c_w[c]   = 6'd8 + {2'b0, ccfg[c][3:0]} + (ccfg[c][15] ? 6'd16 : 6'd0);
      c_off[c] = nxt_pos - ccfg[c][13:4];
      c_hit[c] = c_en[c] && (nxt_pos == ccfg[c][13:4]);
      c_in[c]  = c_en[c] && (nxt_pos >= ccfg[c][13:4]) && (c_off[c] < {4'b0, c_w[c]});
      c_ld[c]  = pack ? fetch : c_hit[c];
      c_cur[c] = c_ld[c] ? c_new[c] : smp[c];
      c_bit[c] = c_in[c] && (c_off[c] < 10'd32) && c_cur[c][5'd31 - c_off[c][4:0]];
    end

  assign nxt_bit = c_in[0] ? c_bit[0] : c_bit[1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      active <= 1'b0; pos <= '0; sd_r <= 1'b0; fs_r <= 1'b0; tx_err <= 1'b0;
      smp[0] <= '0; smp[1] <= '0;
    end else if (!en) begin
      active <= 1'b0; pos <= '0; sd_r <= 1'b0; fs_r <= 1'b0; tx_err <= 1'b0;
    end else if (tick) begin
      if (!run) begin
        active <= 1'b0; pos <= '0; sd_r <= 1'b0; fs_r <= 1'b0;
      end else begin
        active <= 1'b1;
        pos    <= nxt_pos;
        sd_r   <= nxt_bit;
        fs_r   <= nxt_pos < sync_len;
        for (int c = 0; c < 2; c++)
          if (c_ld[c]) smp[c] <= c_new[c];
        if (fetch && !s_valid) tx_err <= 1'b1;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync_s1 <= 1'b0; sync_echo <= 1'b0;
    end else if (tick) begin
      sync_s1 <= sync_wr; sync_echo <= sync_s1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      clr_pend <= 1'b0; clr_cnt <= 1'b0; fifo_clr <= 1'b0;
    end else begin
      fifo_clr <= 1'b0;
      if (clr_req) begin
        clr_pend <= 1'b1; clr_cnt <= 1'b0;
      end else if (clr_pend && tick) begin
        if (clr_cnt) begin
          fifo_clr <= 1'b1; clr_pend <= 1'b0;
        end else clr_cnt <= 1'b1;
      end
    end

  assign bclk  = (en && div_cnt >= CW'(HALF)) ^ ~bclk_inv;
  assign fsync = fs_r ^ fs_inv;
  assign sdata = sd_r;
endmodule

module pcm_tx_framer_chk (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic stby_n,
  input logic tx_on,
  input logic s_valid,
  input logic s_ready,
  input logic sdata,
  input logic fifo_clr,
  input logic tx_err
);
  assert_clr_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_clr |=> !fifo_clr);
  assert_ready_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> (en && stby_n && tx_on));
  assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_err && en) |=> (tx_err || !en));
  assert_underflow_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (s_ready && !s_valid) |=> tx_err);
  assert_idle_data_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !sdata);
endmodule

bind pcm_tx_framer pcm_tx_framer_chk i_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .stby_n(stby_n), .tx_on(tx_on),
  .s_valid(s_valid), .s_ready(s_ready), .sdata(sdata),
  .fifo_clr(fifo_clr), .tx_err(tx_err)
);

// File: tb/test_pcm_tx_framer.sv
module test_pcm_tx_framer;
  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, stby_n = 1'b0, tx_on = 1'b0;
  logic [9:0] frame_len = 10'd0, sync_len = 10'd0;
  logic pack = 1'b0, bclk_inv = 1'b1, fs_inv = 1'b1;
  logic [31:0] chan_cfg = 32'd0;
  logic [31:0] s_data;
  logic s_valid, s_ready, sync_wr = 1'b0, sync_echo, clr_req = 1'b0, fifo_clr;
  logic bclk, fsync, sdata, tx_err;

  pcm_tx_framer #(.CLK_DIV(2)) i_pcm_tx_framer (
    .clk(clk), .rst_n(rst_n), .en(en), .stby_n(stby_n), .tx_on(tx_on),
    .frame_len(frame_len), .sync_len(sync_len), .pack(pack),
    .bclk_inv(bclk_inv), .fs_inv(fs_inv), .chan_cfg(chan_cfg),
    .s_data(s_data), .s_valid(s_valid), .s_ready(s_ready),
    .sync_wr(sync_wr), .sync_echo(sync_echo), .clr_req(clr_req),
    .fifo_clr(fifo_clr), .bclk(bclk), .fsync(fsync), .sdata(sdata),
    .tx_err(tx_err)
  );

  always #5 clk = ~clk;

  logic [31:0] words [64];
  int  widx;
  logic valid_en = 1'b1;
  assign s_valid = valid_en;
  assign s_data  = words[widx[5:0]];
  always @(posedge clk or negedge rst_n)
    if (!rst_n) widx <= 0;
    else if (s_ready && s_valid) widx <= widx + 1;

  int nvec = 0, nfail = 0;
  bit finished = 0;
  int st [2], wc [2], we [2], ce [2];

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic rawb();
    return bclk ^ ~bclk_inv;
  endfunction
  function automatic logic rawfs();
    return fsync ^ fs_inv;
  endfunction
  function automatic int wid(input int c);
    return 8 + wc[c] + 16 * we[c];
  endfunction

  task automatic set_chan();
    chan_cfg = {we[0][0], ce[0][0], st[0][9:0], wc[0][3:0],
                we[1][0], ce[1][0], st[1][9:0], wc[1][3:0]};
  endtask

  task automatic do_reset();
    rst_n = 1'b0; en = 1'b0; stby_n = 1'b0; tx_on = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wait_fall(output int pulses);
    logic prev;
    bit done;
    pulses = 0; done = 0; prev = rawb();
    while (!done) begin
      @(negedge clk);
      if (fifo_clr) pulses++;
      if (prev && !rawb()) done = 1;
      prev = rawb();
    end
  endtask

  task automatic wait_low();
    while (rawb()) @(negedge clk);
  endtask

  function automatic bit ebit(input int p, input int c, input logic [31:0] m);
    int k;
    if (ce[c] != 0 && p >= st[c] && p < st[c] + wid(c)) begin
      k = p - st[c];
      if (k < 32) return m[31 - k];
    end
    return 1'b0;
  endfunction

  task automatic check_frames(input int nfr, input string tag, input bit starve);
    bit sd_s [2048];
    bit fs_s [2048];
    int rise [8];
    int nb, nr, wi, lim, fsn, bad, badp;
    logic prevb, prevfs, b, f;
    logic [31:0] m0, m1, w;
    bit e, a;
    nb = 0; nr = 0; prevfs = 1'b1; prevb = rawb(); lim = 0;
    while (nr < nfr + 1 && nb < 2048 && lim < 20000) begin
      @(negedge clk);
      lim++;
      b = rawb();
      if (b && !prevb) begin
        f = rawfs();
        if (f && !prevfs) begin rise[nr] = nb; nr++; end
        sd_s[nb] = sdata; fs_s[nb] = f; nb++; prevfs = f;
      end
      prevb = b;
    end
    chk(nr == nfr + 1, {tag, " R1 frame starts"}, nr, nfr + 1);
    if (nr != nfr + 1) return;
    wi = 0;
    for (int fr = 0; fr < nfr; fr++) begin
      chk(rise[fr+1] - rise[fr] == frame_len + 1, {tag, " R1 frame length"},
          rise[fr+1] - rise[fr], frame_len + 1);
      fsn = 0;
      for (int p = rise[fr]; p < rise[fr+1]; p++) fsn += fs_s[p];
      chk(fsn == sync_len, {tag, " R1 sync width"}, fsn, sync_len);
      if (pack) begin
        w = 32'd0;
        if (ce[0] != 0 || ce[1] != 0) begin w = words[wi]; wi++; end
        m0 = {w[31:16], 16'h0}; m1 = {w[15:0], 16'h0};
      end else begin
        m0 = 32'd0; m1 = 32'd0;
        if (ce[0] != 0) begin m0 = words[wi]; wi++; end
        if (ce[1] != 0) begin m1 = words[wi]; wi++; end
      end
      if (starve) begin m0 = 32'd0; m1 = 32'd0; end
      bad = 0; badp = -1; a = 0; e = 0;
      for (int p = 0; p < rise[fr+1] - rise[fr]; p++) begin
        bit eb;
        eb = (ce[0] != 0 && p >= st[0] && p < st[0] + wid(0)) ? ebit(p, 0, m0) : ebit(p, 1, m1);
        if (sd_s[rise[fr] + p] != eb && bad == 0) begin
          badp = p; a = sd_s[rise[fr] + p]; e = eb;
        end
        if (sd_s[rise[fr] + p] != eb) bad++;
      end
      if (bad != 0) $display("  frame %0d first bad bit at position %0d", fr, badp);
      chk(bad == 0, {tag, " serial data"}, a, e);
    end
  endtask

  task automatic run_frames(input int nfr, input string tag);
    for (int i = 0; i < 64; i++) words[i] = $urandom;
    do_reset();
    set_chan();
    en = 1'b1; stby_n = 1'b1; tx_on = 1'b1;
    check_frames(nfr, tag, 1'b0);
  endtask

  task automatic cfg_std(input int len, input int code, input int ext);
    frame_len = 10'(len - 1); sync_len = 10'(len / 2);
    st[0] = 1; st[1] = len / 2 + 1;
    wc[0] = code; wc[1] = code; we[0] = ext; we[1] = ext; ce[0] = 1; ce[1] = 1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nfail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    int p1, p2, nf, bad, lim;
    logic prev, old;
    void'($urandom(32'd4242));
    for (int i = 0; i < 64; i++) words[i] = $urandom;

    // R11 reset state
    do_reset();
    @(negedge clk);
    chk(sdata == 1'b0 && s_ready == 1'b0, "R11 data/ready idle", {sdata, s_ready}, 0);
    chk(tx_err == 1'b0 && sync_echo == 1'b0 && fifo_clr == 1'b0, "R11 flags idle",
        {tx_err, sync_echo, fifo_clr}, 0);
    chk(bclk == 1'b0 && fsync == 1'b1, "R11 clock/sync rest level", {bclk, fsync}, 2'b01);

    // R3: standard I2S, 16-bit channels in 40-bit frame
    pack = 1'b0; bclk_inv = 1'b1; fs_inv = 1'b1;
    cfg_std(40, 8, 0);
    run_frames(3, "R3 std16");

    // R2: width extension gives 32-bit channels
    cfg_std(80, 8, 1);
    run_frames(3, "R2 ext32");

    // R4: packed pair words
    pack = 1'b1;
    cfg_std(40, 8, 0);
    run_frames(3, "R4 packed");

    // R4: packed with channel 1 disabled, word taken at channel 2
    ce[0] = 0;
    run_frames(2, "R4 packed ch2 only");
    pack = 1'b0;

    // R5 / R2 / R3: random frames, widths, gaps, polarities and packing
    for (int t = 0; t < 10; t++) begin
      int len;
      wc[0] = $urandom % 16; we[0] = $urandom % 2;
      wc[1] = $urandom % 16; we[1] = $urandom % 2;
      ce[0] = ($urandom % 4) != 0; ce[1] = ($urandom % 4) != 0;
      st[0] = $urandom % 3;
      st[1] = st[0] + wid(0) + ($urandom % 4);
      len = st[1] + wid(1) + ($urandom % 9);
      frame_len = 10'(len - 1);
      sync_len = 10'(1 + ($urandom % (len - 1)));
      pack = $urandom % 2;
      if (pack) begin wc[0] = $urandom % 16; wc[1] = $urandom % 16; end
      bclk_inv = $urandom % 2; fs_inv = $urandom % 2;
      run_frames(3, "R5 random");
    end
    bclk_inv = 1'b1; fs_inv = 1'b1; pack = 1'b0;

    // R6: starvation sends zeros and sets sticky error
    cfg_std(40, 8, 0);
    do_reset();
    set_chan();
    valid_en = 1'b0;
    chk(tx_err == 1'b0, "R6 error clear before run", tx_err, 0);
    en = 1'b1; stby_n = 1'b1; tx_on = 1'b1;
    check_frames(1, "R6 underflow", 1'b1);
    chk(tx_err == 1'b1, "R6 error set", tx_err, 1);
    valid_en = 1'b1;
    repeat (6) @(negedge clk);
    chk(tx_err == 1'b1, "R6 error sticky", tx_err, 1);
    en = 1'b0;
    repeat (2) @(negedge clk);
    chk(tx_err == 1'b0, "R6 error cleared by disable", tx_err, 0);

    // R7: tx_on low, then standby
    do_reset();
    set_chan();
    en = 1'b1; stby_n = 1'b1; tx_on = 1'b0;
    bad = 0;
    repeat (100) begin @(negedge clk); if (rawfs()) bad++; end
    chk(widx == 0 && bad == 0, "R7 tx_on low idle", widx + bad, 0);
    stby_n = 1'b0; tx_on = 1'b1;
    bad = 0;
    repeat (100) begin @(negedge clk); if (rawfs()) bad++; end
    chk(widx == 0 && bad == 0, "R7 standby idle", widx + bad, 0);

    // R8: wake-up delay
    wait_low();
    stby_n = 1'b1;
    nf = 0; prev = rawb(); lim = 0;
    while (!rawfs() && lim < 200) begin
      @(negedge clk);
      lim++;
      if (prev && !rawb()) nf++;
      prev = rawb();
    end
    chk(nf == 5, "R8 first frame bit clock", nf, 5);

    // R9: sync echo
    for (int k = 0; k < 2; k++) begin
      repeat (8) @(negedge clk);
      wait_low();
      old = sync_echo;
      sync_wr = ~sync_wr;
      wait_fall(p1);
      chk(sync_echo == old, "R9 echo after one bit clock", sync_echo, old);
      wait_fall(p1);
      chk(sync_echo == sync_wr, "R9 echo after two bit clocks", sync_echo, sync_wr);
    end

    // R10: clear strobe
    repeat (4) @(negedge clk);
    wait_low();
    clr_req = 1'b1;
    @(negedge clk);
    clr_req = 1'b0;
    wait_fall(p1);
    chk(p1 == 0 && fifo_clr == 1'b0, "R10 no strobe after one bit clock", p1, 0);
    wait_fall(p2);
    chk(p2 == 1 && fifo_clr == 1'b1, "R10 strobe on second bit clock", p2, 1);
    @(negedge clk);
    chk(fifo_clr == 1'b0, "R10 strobe single cycle", fifo_clr, 0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule